// File: doc/BRIEF.md
# Multi-Port DRAM Command Arbiter

This block chooses, once per clock, which of four requesters gets the next DRAM command. Every requester drives a request that carries a priority value, a rank, a bank, a row and a read/write flag. The arbiter keeps its own record of which row is open in every bank of both ranks. From that record it works out the next command each request needs: PRECHARGE when another row is open, ACTIVATE when the bank is closed, and READ or WRITE when the wanted row is already open. Each bank also holds three down-counters, one each for precharge-to-activate, activate-to-access and activate-to-precharge spacing. A request whose next command would break one of these spacings is not ready.

Among the ready requests the one with the largest priority wins, so a lower-priority open-row hit can go ahead of a higher-priority request that is still waiting on bank timing. The chosen command appears on registered outputs in the cycle after the edge that chose it, and a rank select goes low with it. A READ or WRITE also sends a one-cycle grant pulse to its port. At that point the requester removes or replaces its request. PRECHARGE and ACTIVATE leave the request standing.

Top module: `dram_cmd_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, cmdValid and grant are 0 and csN is all ones; every bank starts closed, so the first request to any bank yields ACTIVATE.
- R2: At most one command is issued per cycle; outside command cycles grant is 0 and csN is all ones.
- R3: A request to a closed bank is served with ACTIVATE (cmdKind 1) carrying the request's rank, bank and row, followed by its access.
- R4: A request to a bank holding a different open row is served with PRECHARGE (cmdKind 0), then ACTIVATE, then the access. cmdRow carries the request's row for every command kind.
- R5: A request whose row is open is served with READ (cmdKind 2) when its write flag is 0, or WRITE (cmdKind 3) when it is 1. grant bit p is 1 for exactly the cycle in which that command is shown with cmdPort equal to p.
- R6: Among ready requests, the larger 3-bit priority value wins. Equal priorities go to the lower port index.
- R7: A request held back by bank timing is skipped, and a ready request of lower priority is issued in that cycle.
- R8: ACTIVATE to a bank comes no sooner than T_RP cycles after that bank's PRECHARGE.
- R9: READ or WRITE to a bank comes no sooner than T_RCD cycles after that bank's ACTIVATE.
- R10: PRECHARGE to a bank comes no sooner than T_RAS cycles after that bank's ACTIVATE.
- R11: The two ranks keep separate open-row state. csN is active low with bit r for rank r, and exactly one bit is low during a command.
- R12: Without a valid request no command is issued. Every issued command belongs to a port whose request was valid at the deciding edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_PORTS | Request present, one bit per port |
| reqPrio | input | NUM_PORTS*PRIO_W | Priority per port, larger wins |
| reqRank | input | NUM_PORTS*$clog2(NUM_RANKS) | Target rank per port |
| reqBank | input | NUM_PORTS*BANK_W | Target bank per port |
| reqRow | input | NUM_PORTS*ROW_W | Target row per port |
| reqWrite | input | NUM_PORTS | 1 = write access, 0 = read access |
| cmdValid | output | 1 | A command is issued this cycle |
| cmdKind | output | 2 | 0 PRECHARGE, 1 ACTIVATE, 2 READ, 3 WRITE |
| cmdRank | output | $clog2(NUM_RANKS) | Rank of the command |
| cmdBank | output | BANK_W | Bank of the command |
| cmdRow | output | ROW_W | Row of the owning request |
| cmdPort | output | $clog2(NUM_PORTS) | Port that owns the command |
| csN | output | NUM_RANKS | Active-low rank selects |
| grant | output | NUM_PORTS | One-cycle pulse on READ/WRITE issue |

## Verification
The first pattern is a single read to a closed bank. It shows the ACTIVATE-then-READ path and the activate-to-access spacing. A write followed at once by a different row on the same bank brings in the precharge path, and the measured gaps separate the activate-to-precharge spacing from the precharge-to-activate spacing. Three ports with mixed and equal priorities on distinct closed banks separate priority order from the tie rule. A high-priority row conflict set against a low-priority row hit on the same bank shows that the arbiter skips blocked requests rather than stalling on them. Two ports that use the same bank number on different ranks, followed by a hit on the second rank, show that open-row state and chip selects are kept per rank.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

  // Command codes driven on cmdKind
  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmdKind_e;

  // Strobes from control to the bank datapath
  typedef struct packed {
    logic     fire;
    cmdKind_e kind;
  } arbStrobe_t;

endpackage

// File: rtl/dram_arb_banks.sv
module dram_arb_banks
  import dram_arb_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int ROW_W     = 13,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  arbStrobe_t                  strobe,
  input  logic [$clog2(NUM_SLOTS)-1:0] slotSel,
  input  logic [ROW_W-1:0]            rowSel,
  output logic [NUM_SLOTS-1:0]        openVld,
  output logic [ROW_W-1:0]            openRow [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0]        actOk,
  output logic [NUM_SLOTS-1:0]        rwOk,
  output logic [NUM_SLOTS-1:0]        preOk
);

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int T_MAX  = (T_RAS > T_RP) ? ((T_RAS > T_RCD) ? T_RAS : T_RCD)
                                         : ((T_RP > T_RCD) ? T_RP : T_RCD);
  localparam int CW     = $clog2(T_MAX + 1);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic            vldQ;
    logic [ROW_W-1:0] rowQ;
    logic [CW-1:0]   rpCnt, rcdCnt, rasCnt;
    logic            hitSel;

    assign hitSel = strobe.fire && (slotSel == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vldQ   <= 1'b0;
        rowQ   <= '0;
        rpCnt  <= '0;
        rcdCnt <= '0;
        rasCnt <= '0;
      end else begin
        rpCnt  <= (rpCnt  != '0) ? rpCnt  - 1'b1 : '0;
        rcdCnt <= (rcdCnt != '0) ? rcdCnt - 1'b1 : '0;
        rasCnt <= (rasCnt != '0) ? rasCnt - 1'b1 : '0;
        if (hitSel) begin
          case (strobe.kind)
            CMD_PRE: begin
              vldQ  <= 1'b0;
              rpCnt <= CW'(T_RP - 1);
            end
            CMD_ACT: begin
              vldQ   <= 1'b1;
              rowQ   <= rowSel;
              rcdCnt <= CW'(T_RCD - 1);
              rasCnt <= CW'(T_RAS - 1);
            end
            default: ;
          endcase
        end
      end
    end

    assign openVld[s] = vldQ;
    assign openRow[s] = rowQ;
    assign actOk[s]   = (rpCnt == '0);
    assign rwOk[s]    = (rcdCnt == '0);
    assign preOk[s]   = (rasCnt == '0);
  end

endmodule

// File: rtl/dram_arb_ctrl.sv
module dram_arb_ctrl
  import dram_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_RANKS = 2,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 13,
  parameter int PRIO_W    = 3
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_PORTS-1:0]                  reqValid,
  input  logic [NUM_PORTS*PRIO_W-1:0]           reqPrio,
  input  logic [NUM_PORTS*$clog2(NUM_RANKS)-1:0] reqRank,
  input  logic [NUM_PORTS*BANK_W-1:0]           reqBank,
  input  logic [NUM_PORTS*ROW_W-1:0]            reqRow,
  input  logic [NUM_PORTS-1:0]                  reqWrite,
  input  logic [NUM_RANKS*(2**BANK_W)-1:0]      openVld,
  input  logic [ROW_W-1:0]                      openRow [NUM_RANKS*(2**BANK_W)],
  input  logic [NUM_RANKS*(2**BANK_W)-1:0]      actOk,
  input  logic [NUM_RANKS*(2**BANK_W)-1:0]      rwOk,
  input  logic [NUM_RANKS*(2**BANK_W)-1:0]      preOk,
  output arbStrobe_t                            strobe,
  output logic [$clog2(NUM_RANKS)+BANK_W-1:0]   slotSel,
  output logic [ROW_W-1:0]                      rowSel,
  output logic                                  cmdValid,
  output logic [1:0]                            cmdKind,
  output logic [$clog2(NUM_RANKS)-1:0]          cmdRank,
  output logic [BANK_W-1:0]                     cmdBank,
  output logic [ROW_W-1:0]                      cmdRow,
  output logic [$clog2(NUM_PORTS)-1:0]          cmdPort,
  output logic [NUM_RANKS-1:0]                  csN,
  output logic [NUM_PORTS-1:0]                  grant
);

  localparam int RANK_W = $clog2(NUM_RANKS);
  localparam int SLOT_W = RANK_W + BANK_W;
  localparam int PORT_W = $clog2(NUM_PORTS);

  logic [SLOT_W-1:0] portSlot [NUM_PORTS];
  logic [ROW_W-1:0]  portRow  [NUM_PORTS];
  logic [PRIO_W-1:0] portPrio [NUM_PORTS];
  cmdKind_e          portKind [NUM_PORTS];
  logic [NUM_PORTS-1:0] portReady;

  // Per-port classification of the next needed command
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic isOpen, isHit;
    assign portSlot[p] = {reqRank[p*RANK_W +: RANK_W], reqBank[p*BANK_W +: BANK_W]};
    assign portRow[p]  = reqRow[p*ROW_W +: ROW_W];
    assign portPrio[p] = reqPrio[p*PRIO_W +: PRIO_W];
    assign isOpen      = openVld[portSlot[p]];
    assign isHit       = isOpen && (openRow[portSlot[p]] == portRow[p]);

    always_comb begin
      if (isHit) begin
        portKind[p]  = reqWrite[p] ? CMD_WR : CMD_RD;
        portReady[p] = reqValid[p] && rwOk[portSlot[p]];
      end else if (isOpen) begin
        portKind[p]  = CMD_PRE;
        portReady[p] = reqValid[p] && preOk[portSlot[p]];
      end else begin
        portKind[p]  = CMD_ACT;
        portReady[p] = reqValid[p] && actOk[portSlot[p]];
      end
    end
  end

  // Highest priority among ready ports, lowest index on ties
  logic              found;
  logic [PORT_W-1:0] bestIdx;
  logic [PRIO_W-1:0] bestPrio;

  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (portReady[p] && (!found || (portPrio[p] > bestPrio))) begin
        found    = 1'b1;
        bestIdx  = PORT_W'(p);
        bestPrio = portPrio[p];
      end
    end
  end

  assign strobe.fire = found;
  assign strobe.kind = portKind[bestIdx];
  assign slotSel     = portSlot[bestIdx];
  assign rowSel      = portRow[bestIdx];

  logic isAccess;
  assign isAccess = (portKind[bestIdx] == CMD_RD) || (portKind[bestIdx] == CMD_WR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdKind  <= '0;
      cmdRank  <= '0;
      cmdBank  <= '0;
      cmdRow   <= '0;
      cmdPort  <= '0;
      csN      <= '1;
      grant    <= '0;
    end else begin
      cmdValid <= found;
      csN      <= '1;
      grant    <= '0;
      if (found) begin
        cmdKind <= portKind[bestIdx];
        cmdRank <= slotSel[SLOT_W-1 -: RANK_W];
        cmdBank <= slotSel[BANK_W-1:0];
        cmdRow  <= rowSel;
        cmdPort <= bestIdx;
        csN     <= ~(NUM_RANKS'(1) << slotSel[SLOT_W-1 -: RANK_W]);
        if (isAccess) grant <= NUM_PORTS'(1) << bestIdx;
      end
    end
  end

endmodule

// File: rtl/dram_cmd_arbiter.sv
module dram_cmd_arbiter
  import dram_arb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int NUM_RANKS = 2,
  parameter int BANK_W    = 3,
  parameter int ROW_W     = 13,
  parameter int PRIO_W    = 3,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [NUM_PORTS-1:0]                   reqValid,
  input  logic [NUM_PORTS*PRIO_W-1:0]            reqPrio,
  input  logic [NUM_PORTS*$clog2(NUM_RANKS)-1:0] reqRank,
  input  logic [NUM_PORTS*BANK_W-1:0]            reqBank,
  input  logic [NUM_PORTS*ROW_W-1:0]             reqRow,
  input  logic [NUM_PORTS-1:0]                   reqWrite,
  output logic                                   cmdValid,
  output logic [1:0]                             cmdKind,
  output logic [$clog2(NUM_RANKS)-1:0]           cmdRank,
  output logic [BANK_W-1:0]                      cmdBank,
  output logic [ROW_W-1:0]                       cmdRow,
  output logic [$clog2(NUM_PORTS)-1:0]           cmdPort,
  output logic [NUM_RANKS-1:0]                   csN,
  output logic [NUM_PORTS-1:0]                   grant
);

  localparam int SLOT_W    = $clog2(NUM_RANKS) + BANK_W;
  localparam int NUM_SLOTS = NUM_RANKS * (2**BANK_W);

  arbStrobe_t            strobe;
  logic [SLOT_W-1:0]     slotSel;
  logic [ROW_W-1:0]      rowSel;
  logic [NUM_SLOTS-1:0]  openVld, actOk, rwOk, preOk;
  logic [ROW_W-1:0]      openRow [NUM_SLOTS];

  dram_arb_ctrl #(
    .NUM_PORTS(NUM_PORTS), .NUM_RANKS(NUM_RANKS), .BANK_W(BANK_W),
    .ROW_W(ROW_W), .PRIO_W(PRIO_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqPrio(reqPrio), .reqRank(reqRank),
    .reqBank(reqBank), .reqRow(reqRow), .reqWrite(reqWrite),
    .openVld(openVld), .openRow(openRow),
    .actOk(actOk), .rwOk(rwOk), .preOk(preOk),
    .strobe(strobe), .slotSel(slotSel), .rowSel(rowSel),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdRank(cmdRank),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdPort(cmdPort),
    .csN(csN), .grant(grant)
  );

  dram_arb_banks #(
    .NUM_SLOTS(NUM_SLOTS), .ROW_W(ROW_W),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS)
  ) u_banks (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .slotSel(slotSel), .rowSel(rowSel),
    .openVld(openVld), .openRow(openRow),
    .actOk(actOk), .rwOk(rwOk), .preOk(preOk)
  );

endmodule

// File: rtl/dram_arb_checker.sv
module dram_arb_checker #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_RANKS = 2,
  parameter int BANK_W    = 3,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_PORTS-1:0]         reqValid,
  input logic                         cmdValid,
  input logic [1:0]                   cmdKind,
  input logic [$clog2(NUM_RANKS)-1:0] cmdRank,
  input logic [BANK_W-1:0]            cmdBank,
  input logic [$clog2(NUM_PORTS)-1:0] cmdPort,
  input logic [NUM_RANKS-1:0]         csN,
  input logic [NUM_PORTS-1:0]         grant
);

  localparam int NUM_SLOTS = NUM_RANKS * (2**BANK_W);
  localparam int SLOT_W    = $clog2(NUM_RANKS) + BANK_W;
  localparam int T_MAX     = (T_RAS > T_RP) ? ((T_RAS > T_RCD) ? T_RAS : T_RCD)
                                            : ((T_RP > T_RCD) ? T_RP : T_RCD);
  localparam int CW        = $clog2(T_MAX + 2);

  logic [SLOT_W-1:0]    cmdSlot;
  logic [NUM_PORTS-1:0] reqValidQ;
  logic [CW-1:0]        sincePre [NUM_SLOTS];
  logic [CW-1:0]        sinceAct [NUM_SLOTS];

  assign cmdSlot = {cmdRank, cmdBank};

  always_ff @(posedge clk) begin
    if (!rstN) reqValidQ <= '0;
    else       reqValidQ <= reqValid;
  end

  // Independent spacing counters, one pair per bank slot
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sincePre[s] <= '1;
        sinceAct[s] <= '1;
      end else begin
        sincePre[s] <= (sincePre[s] != '1) ? sincePre[s] + 1'b1 : sincePre[s];
        sinceAct[s] <= (sinceAct[s] != '1) ? sinceAct[s] + 1'b1 : sinceAct[s];
        if (cmdValid && cmdSlot == SLOT_W'(s)) begin
          if (cmdKind == 2'd0) sincePre[s] <= CW'(1);
          if (cmdKind == 2'd1) sinceAct[s] <= CW'(1);
        end
      end
    end
  end

  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> (grant == '0 && csN == '1));

  a_r5_grant_matches: assert property (@(posedge clk) disable iff (!rstN)
    (grant != '0) |-> (cmdValid && (cmdKind == 2'd2 || cmdKind == 2'd3) && grant[cmdPort]));

  a_r5_access_grants: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdKind == 2'd2 || cmdKind == 2'd3)) |-> grant[cmdPort]);

  a_r11_one_rank: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ($countones(~csN) == 1 && !csN[cmdRank]));

  a_r12_owner_valid: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> reqValidQ[cmdPort]);

  a_r8_trp: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 2'd1) |-> (sincePre[cmdSlot] >= CW'(T_RP)));

  a_r9_trcd: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdKind == 2'd2 || cmdKind == 2'd3)) |-> (sinceAct[cmdSlot] >= CW'(T_RCD)));

  a_r10_tras: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == 2'd0) |-> (sinceAct[cmdSlot] >= CW'(T_RAS)));

endmodule

bind dram_cmd_arbiter dram_arb_checker #(
  .NUM_PORTS(NUM_PORTS), .NUM_RANKS(NUM_RANKS), .BANK_W(BANK_W),
  .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid),
  .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdRank(cmdRank),
  .cmdBank(cmdBank), .cmdPort(cmdPort), .csN(csN), .grant(grant)
);

// File: tb/dram_cmd_arbiter_tb.sv
module dram_cmd_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int T_RP = 3;
  localparam int T_RCD = 2;
  localparam int T_RAS = 5;

  typedef struct packed {
    logic [1:0]  kind;
    logic        rank;
    logic [2:0]  bank;
    logic [12:0] row;
    logic [1:0]  port;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0]    reqValid;
  logic [NP*3-1:0]  reqPrio;
  logic [NP-1:0]    reqRank;
  logic [NP*3-1:0]  reqBank;
  logic [NP*13-1:0] reqRow;
  logic [NP-1:0]    reqWrite;
  logic        cmdValid;
  logic [1:0]  cmdKind;
  logic        cmdRank;
  logic [2:0]  cmdBank;
  logic [12:0] cmdRow;
  logic [1:0]  cmdPort;
  logic [1:0]  csN;
  logic [NP-1:0] grant;

  logic        rV [NP];
  logic [2:0]  rP [NP];
  logic        rR [NP];
  logic [2:0]  rB [NP];
  logic [12:0] rW [NP];
  logic        rWr [NP];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      reqValid[p]        = rV[p];
      reqPrio[p*3 +: 3]  = rP[p];
      reqRank[p]         = rR[p];
      reqBank[p*3 +: 3]  = rB[p];
      reqRow[p*13 +: 13] = rW[p];
      reqWrite[p]        = rWr[p];
    end
  end

  dram_cmd_arbiter #(
    .NUM_PORTS(NP), .NUM_RANKS(2), .BANK_W(3), .ROW_W(13), .PRIO_W(3),
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RAS(T_RAS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPrio(reqPrio),
    .reqRank(reqRank), .reqBank(reqBank), .reqRow(reqRow), .reqWrite(reqWrite),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdRank(cmdRank), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdPort(cmdPort), .csN(csN), .grant(grant)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  int cycle = 0;
  string curTag = "R2";
  exp_t expQ[$];
  int stampQ[$];
  bit done = 1'b0;

  always @(posedge clk) cycle++;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Monitor: pops the scoreboard whenever a command appears
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (cmdValid) begin
        exp_t got;
        got = '{kind: cmdKind, rank: cmdRank, bank: cmdBank, row: cmdRow, port: cmdPort};
        stampQ.push_back(cycle);
        if (expQ.size() == 0) begin
          check(1'b0, "R12", "unexpected command", 64'(got), 64'(0));
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(got == e, curTag, "command", 64'(got), 64'(e));
          check(csN == ~(2'b01 << e.rank), "R11", "csN", 64'(csN), 64'(~(2'b01 << e.rank) & 2'b11));
          check(grant == ((e.kind >= 2'd2) ? (4'b0001 << e.port) : 4'b0000), "R5", "grant",
                64'(grant), 64'((e.kind >= 2'd2) ? (4'b0001 << e.port) : 4'b0000));
        end
      end else begin
        check(grant == '0 && csN == 2'b11, "R2", "idle outputs", 64'({grant, csN}), 64'({4'b0, 2'b11}));
      end
    end
  end

  task automatic expect_cmd(logic [1:0] k, logic rk, logic [2:0] bk, logic [12:0] rw, logic [1:0] pt);
    expQ.push_back('{kind: k, rank: rk, bank: bk, row: rw, port: pt});
  endtask

  // Driver: raise a request and hold it until the port's grant is seen
  task automatic serve(int p, logic [2:0] prio, logic rk, logic [2:0] bk, logic [12:0] rw, logic wr);
    rP[p] = prio; rR[p] = rk; rB[p] = bk; rW[p] = rw; rWr[p] = wr; rV[p] = 1'b1;
    forever begin
      @(negedge clk);
      if (grant[p]) break;
    end
    rV[p] = 1'b0;
  endtask

  task automatic do_reset();
    rstN = 1'b0;
    for (int p = 0; p < NP; p++) begin
      rV[p] = 1'b0; rP[p] = '0; rR[p] = 1'b0; rB[p] = '0; rW[p] = '0; rWr[p] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    stampQ.delete();
  endtask

  task automatic end_scenario(string tag);
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, tag, "pending expected commands", 64'(expQ.size()), 64'(0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 64'(cycle), 64'(0));
    done = 1'b1;
    summary();
  end

  initial begin
    do_reset();
    rstN = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(cmdValid == 1'b0, "R1", "cmdValid in reset", 64'(cmdValid), 64'(0));
    check(grant == '0, "R1", "grant in reset", 64'(grant), 64'(0));
    check(csN == 2'b11, "R1", "csN in reset", 64'(csN), 64'(3));
    rstN = 1'b1;
    @(negedge clk);
    check(cmdValid == 1'b0, "R1", "cmdValid after reset", 64'(cmdValid), 64'(0));
    // R12: no requests, no commands
    curTag = "R12";
    end_scenario("R12");

    // R3, R9: closed bank read
    do_reset();
    curTag = "R3";
    expect_cmd(2'd1, 1'b0, 3'd1, 13'h055, 2'd0);
    expect_cmd(2'd2, 1'b0, 3'd1, 13'h055, 2'd0);
    serve(0, 3'd4, 1'b0, 3'd1, 13'h055, 1'b0);
    end_scenario("R3");
    check(stampQ.size() == 2 && stampQ[1] - stampQ[0] == T_RCD, "R9", "ACT to READ gap",
          64'(stampQ[1] - stampQ[0]), 64'(T_RCD));

    // R4, R8, R10: row conflict on the same bank, writes
    do_reset();
    curTag = "R4";
    expect_cmd(2'd1, 1'b0, 3'd2, 13'h0aa, 2'd0);
    expect_cmd(2'd3, 1'b0, 3'd2, 13'h0aa, 2'd0);
    expect_cmd(2'd0, 1'b0, 3'd2, 13'h0bb, 2'd0);
    expect_cmd(2'd1, 1'b0, 3'd2, 13'h0bb, 2'd0);
    expect_cmd(2'd3, 1'b0, 3'd2, 13'h0bb, 2'd0);
    serve(0, 3'd1, 1'b0, 3'd2, 13'h0aa, 1'b1);
    serve(0, 3'd1, 1'b0, 3'd2, 13'h0bb, 1'b1);
    end_scenario("R4");
    if (stampQ.size() == 5) begin
      check(stampQ[2] - stampQ[0] == T_RAS, "R10", "ACT to PRE gap", 64'(stampQ[2] - stampQ[0]), 64'(T_RAS));
      check(stampQ[3] - stampQ[2] == T_RP, "R8", "PRE to ACT gap", 64'(stampQ[3] - stampQ[2]), 64'(T_RP));
      check(stampQ[4] - stampQ[3] == T_RCD, "R9", "ACT to WRITE gap", 64'(stampQ[4] - stampQ[3]), 64'(T_RCD));
    end else begin
      check(1'b0, "R8", "command count", 64'(stampQ.size()), 64'(5));
    end

    // R6: priority order and tie to the lower index
    do_reset();
    curTag = "R6";
    expect_cmd(2'd1, 1'b0, 3'd2, 13'h002, 2'd2);
    expect_cmd(2'd1, 1'b0, 3'd3, 13'h003, 2'd3);
    expect_cmd(2'd2, 1'b0, 3'd2, 13'h002, 2'd2);
    expect_cmd(2'd2, 1'b0, 3'd3, 13'h003, 2'd3);
    expect_cmd(2'd1, 1'b0, 3'd1, 13'h001, 2'd1);
    expect_cmd(2'd2, 1'b0, 3'd1, 13'h001, 2'd1);
    fork
      serve(1, 3'd2, 1'b0, 3'd1, 13'h001, 1'b0);
      serve(2, 3'd5, 1'b0, 3'd2, 13'h002, 1'b0);
      serve(3, 3'd5, 1'b0, 3'd3, 13'h003, 1'b0);
    join
    end_scenario("R6");

    // R7: blocked high-priority conflict skipped for a low-priority hit
    do_reset();
    curTag = "R7";
    expect_cmd(2'd1, 1'b0, 3'd0, 13'h010, 2'd0);
    expect_cmd(2'd2, 1'b0, 3'd0, 13'h010, 2'd0);
    expect_cmd(2'd2, 1'b0, 3'd0, 13'h010, 2'd3);
    expect_cmd(2'd0, 1'b0, 3'd0, 13'h020, 2'd0);
    expect_cmd(2'd1, 1'b0, 3'd0, 13'h020, 2'd0);
    expect_cmd(2'd2, 1'b0, 3'd0, 13'h020, 2'd0);
    serve(0, 3'd7, 1'b0, 3'd0, 13'h010, 1'b0);
    fork
      serve(0, 3'd7, 1'b0, 3'd0, 13'h020, 1'b0);
      serve(3, 3'd1, 1'b0, 3'd0, 13'h010, 1'b0);
    join
    end_scenario("R7");

    // R11: same bank number on both ranks, then a hit on rank 1
    do_reset();
    curTag = "R11";
    expect_cmd(2'd1, 1'b0, 3'd1, 13'h005, 2'd0);
    expect_cmd(2'd1, 1'b1, 3'd1, 13'h009, 2'd1);
    expect_cmd(2'd2, 1'b0, 3'd1, 13'h005, 2'd0);
    expect_cmd(2'd2, 1'b1, 3'd1, 13'h009, 2'd1);
    expect_cmd(2'd2, 1'b1, 3'd1, 13'h009, 2'd0);
    fork
      serve(0, 3'd3, 1'b0, 3'd1, 13'h005, 1'b0);
      serve(1, 3'd3, 1'b1, 3'd1, 13'h009, 1'b0);
    join
    serve(0, 3'd3, 1'b1, 3'd1, 13'h009, 1'b0);
    end_scenario("R11");

    done = 1'b1;
    summary();
  end

endmodule